// File: doc/BRIEF.md
# Rotation-Select Low-Toggle Link Codec

This block sits on a point-to-point data link and lowers the number of data wires that change state from one transfer to the next. For each valid word, the encoder looks at three forms of that word: the word as it is, the word rotated left by one bit, and the word rotated right by one bit. It counts how many wires each form would toggle against the value already held on the link. It then registers the form with the lowest count onto the link, together with a two-bit mode code that records which form was sent.

The receive side reads the link value and the mode code and applies the opposite rotation, so the original word comes out exactly one cycle after it was presented. Rotation is circular, so no bit is lost. The link holds its value between valid words, and those idle cycles cause no wire activity.

Top module: `rot_link_codec`

## Requirements
- R1: While reset is asserted (active low), link_data, link_mode and out_valid are all zero.
- R2: link_mode carries 2'b00 when the word is sent unchanged, 2'b01 when it is rotated left by one, and 2'b10 when it is rotated right by one. The encoder never emits 2'b11.
- R3: For every valid word, the number of bits that differ between the new and previous link_data is no greater than the count for any of the three candidate forms.
- R4: When toggle counts tie, the unchanged form wins first, then the right rotation, then the left rotation.
- R5: out_data equals the in_data word that was presented with in_valid on the previous clock edge.
- R6: A cycle with in_valid low leaves link_data and link_mode unchanged.
- R7: out_valid is high in the cycle after the in_valid edge and low otherwise.
- R8: With 8'b01001101 on the link, presenting 8'b10010010 yields link_data 8'b01001001 and link_mode 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies in_data for this cycle |
| in_data | input | W | Word to transmit |
| link_data | output | W | Registered value driven onto the link wires |
| link_mode | output | 2 | Registered code naming the transformation applied |
| out_valid | output | 1 | Decoded word is valid |
| out_data | output | W | Decoded word recovered from the link |

## Verification
The assertions assume that in_data is known (no X bits) whenever in_valid is high, and that in_valid stays low while reset is held. They also assume the link and mode wires reach the decoder unaltered. The stimulus applies reset with in_valid low. It then drives only fully defined words: random values, exact rotations of the current link value, repeated words, all-zeros and all-ones, alternating patterns, and the fixed example pair. Idle cycles are mixed in with valid ones.

// File: rtl/rotc_pkg.sv
package rotc_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_ROTL  = 2'b01,
    MODE_ROTR  = 2'b10,
    MODE_RSVD  = 2'b11
  } rot_mode_e;

  // Candidate slots, listed in tie-break priority order.
  localparam int CAND_N     = 3;
  localparam int SLOT_PLAIN = 0;
  localparam int SLOT_ROTR  = 1;
  localparam int SLOT_ROTL  = 2;

endpackage

// File: rtl/rot_cost.sv
module rot_cost #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  cur,
  input  logic [W-1:0]  cand,
  output logic [CW-1:0] cost
);

  function automatic logic [CW-1:0] diff_bits(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < W; i++) begin
      n = n + CW'(a[i] ^ b[i]);
    end
    return n;
  endfunction

  assign cost = diff_bits(cur, cand);

endmodule

// File: rtl/rot_encoder.sv
module rot_encoder
  import rotc_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic [W-1:0]  link_q,
  output rot_mode_e     mode_q,
  output logic          valid_q,
  output logic [CW-1:0] cost_plain,
  output logic [CW-1:0] cost_rotl,
  output logic [CW-1:0] cost_rotr
);

  function automatic logic [W-1:0] rot_left1(input logic [W-1:0] x);
    return {x[W-2:0], x[W-1]};
  endfunction

  function automatic logic [W-1:0] rot_right1(input logic [W-1:0] x);
    return {x[0], x[W-1:1]};
  endfunction

  logic [W-1:0]  cand  [CAND_N];
  logic [CW-1:0] costs [CAND_N];

  assign cand[SLOT_PLAIN] = in_data;
  assign cand[SLOT_ROTR]  = rot_right1(in_data);
  assign cand[SLOT_ROTL]  = rot_left1(in_data);

  for (genvar g = 0; g < CAND_N; g++) begin : g_cost
    rot_cost #(.W(W), .CW(CW)) u_cost (
      .cur  (link_q),
      .cand (cand[g]),
      .cost (costs[g])
    );
  end

  assign cost_plain = costs[SLOT_PLAIN];
  assign cost_rotr  = costs[SLOT_ROTR];
  assign cost_rotl  = costs[SLOT_ROTL];

  rot_mode_e    pick_mode;
  logic [W-1:0] pick_data;

  always_comb begin
    if (cost_plain <= cost_rotr && cost_plain <= cost_rotl) begin
      pick_mode = MODE_PLAIN;
      pick_data = cand[SLOT_PLAIN];
    end else if (cost_rotr <= cost_rotl) begin
      pick_mode = MODE_ROTR;
      pick_data = cand[SLOT_ROTR];
    end else begin
      pick_mode = MODE_ROTL;
      pick_data = cand[SLOT_ROTL];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q  <= '0;
      mode_q  <= MODE_PLAIN;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        link_q <= pick_data;
        mode_q <= pick_mode;
      end
    end
  end

endmodule

// File: rtl/rot_decoder.sv
module rot_decoder
  import rotc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] link_in,
  input  logic [1:0]   mode_in,
  output logic [W-1:0] word_out
);

  always_comb begin
    unique case (rot_mode_e'(mode_in))
      MODE_ROTL: word_out = {link_in[0], link_in[W-1:1]};
      MODE_ROTR: word_out = {link_in[W-2:0], link_in[W-1]};
      default:   word_out = link_in;
    endcase
  end

endmodule

// File: rtl/rot_link_codec.sv
module rot_link_codec
  import rotc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] link_data,
  output logic [1:0]   link_mode,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  localparam int CW = $clog2(W + 1);

  rot_mode_e     mode_q;
  logic [CW-1:0] cost_plain;
  logic [CW-1:0] cost_rotl;
  logic [CW-1:0] cost_rotr;

  rot_encoder #(.W(W), .CW(CW)) u_enc (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .link_q     (link_data),
    .mode_q     (mode_q),
    .valid_q    (out_valid),
    .cost_plain (cost_plain),
    .cost_rotl  (cost_rotl),
    .cost_rotr  (cost_rotr)
  );

  assign link_mode = mode_q;

  rot_decoder #(.W(W)) u_dec (
    .link_in  (link_data),
    .mode_in  (link_mode),
    .word_out (out_data)
  );

endmodule

// File: rtl/rot_link_codec_chk.sv
module rot_link_codec_chk #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  in_data,
  input logic [W-1:0]  link_data,
  input logic [1:0]    link_mode,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic [CW-1:0] cost_plain,
  input logic [CW-1:0] cost_rotl,
  input logic [CW-1:0] cost_rotr
);

  p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    link_mode != 2'b11);

  p_min_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=>
      ($countones(link_data ^ $past(link_data)) <= $countones($past(in_data) ^ $past(link_data))) &&
      ($countones(link_data ^ $past(link_data)) <=
         $countones({$past(in_data[0]), $past(in_data[W-1:1])} ^ $past(link_data))) &&
      ($countones(link_data ^ $past(link_data)) <=
         $countones({$past(in_data[W-2:0]), $past(in_data[W-1])} ^ $past(link_data))));

  p_tie_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cost_plain <= cost_rotr && cost_plain <= cost_rotl) |=> link_mode == 2'b00);

  p_tie_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cost_plain > cost_rotr && cost_rotr <= cost_rotl) |=> link_mode == 2'b10);

  p_roundtrip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_data == $past(in_data));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(link_data) && $stable(link_mode));

  p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

endmodule

bind rot_link_codec rot_link_codec_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .link_data  (link_data),
  .link_mode  (link_mode),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .cost_plain (cost_plain),
  .cost_rotl  (cost_rotl),
  .cost_rotr  (cost_rotr)
);

// File: tb/rot_link_codec_bench.sv
`timescale 1ns/1ps
module rot_link_codec_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] link_data;
  logic [1:0]   link_mode;
  logic         out_valid;
  logic [W-1:0] out_data;

  always #2.5 clk = ~clk;

  rot_link_codec #(.W(W)) u_rot_link_codec (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .link_data (link_data),
    .link_mode (link_mode),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference state, predicted for the next negedge.
  int ref_link  = 0;
  int ref_mode  = 0;
  int ref_valid = 0;
  int ref_word  = 0;
  int prev_link = 0;
  int tie_seen  = 0;
  int last_in   = 0;

  function automatic int popc(int x);
    int n = 0;
    for (int i = 0; i < W; i++) if ((x >> i) & 1) n++;
    return n;
  endfunction

  function automatic int rl(int x);
    return ((x << 1) | (x >> (W - 1))) & ((1 << W) - 1);
  endfunction

  function automatic int rr(int x);
    return ((x >> 1) | ((x & 1) << (W - 1))) & ((1 << W) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Compare outputs against the model, then present the next input.
  task automatic step(input bit v, input int d);
    int cp, cr, cl, got_cost;
    @(negedge clk);
    chk(int'(out_valid) == ref_valid, "R7 out_valid", int'(out_valid), ref_valid);
    chk(int'(link_data) == ref_link, "R6/R3 link_data", int'(link_data), ref_link);
    chk(int'(link_mode) == ref_mode, tie_seen ? "R4 link_mode tie" : "R2 link_mode",
        int'(link_mode), ref_mode);
    chk(link_mode != 2'b11, "R2 reserved mode", int'(link_mode), 0);
    if (ref_valid != 0) begin
      chk(int'(out_data) == ref_word, "R5 out_data", int'(out_data), ref_word);
      got_cost = popc(int'(link_data) ^ prev_link);
      cp = popc(last_in ^ prev_link);
      cr = popc(rr(last_in) ^ prev_link);
      cl = popc(rl(last_in) ^ prev_link);
      chk(got_cost <= cp && got_cost <= cr && got_cost <= cl, "R3 min toggles",
          got_cost, (cp < cr) ? ((cp < cl) ? cp : cl) : ((cr < cl) ? cr : cl));
    end
    // Predict the state after the coming edge.
    in_valid  = v;
    in_data   = W'(d);
    prev_link = ref_link;
    ref_valid = v;
    tie_seen  = 0;
    if (v) begin
      last_in = d & ((1 << W) - 1);
      cp = popc(last_in ^ ref_link);
      cr = popc(rr(last_in) ^ ref_link);
      cl = popc(rl(last_in) ^ ref_link);
      tie_seen = (cp == cr) || (cp == cl) || (cr == cl);
      ref_word = last_in;
      if (cp <= cr && cp <= cl) begin ref_mode = 0; ref_link = last_in; end
      else if (cr <= cl)        begin ref_mode = 2; ref_link = rr(last_in); end
      else                      begin ref_mode = 1; ref_link = rl(last_in); end
    end
  endtask

  initial begin
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(link_data == '0, "R1 link_data", int'(link_data), 0);
    chk(link_mode == 2'b00, "R1 link_mode", int'(link_mode), 0);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    rst_n = 1'b1;

    // R8: fixed example pair
    step(1, 8'b01001101);
    step(1, 8'b10010010);
    step(0, 0);
    chk(link_data == 8'b01001001, "R8 link_data", int'(link_data), 8'b01001001);
    chk(link_mode == 2'b10, "R8 link_mode", int'(link_mode), 2);

    // R4: repeated word ties to unchanged; all-zero/all-one rotations tie
    step(1, 8'h5A);
    step(1, 8'h5A);
    step(1, 8'h00);
    step(1, 8'hFF);
    step(1, 8'hFF);
    step(1, 8'h55);
    step(1, 8'hAA);
    step(1, 8'h55);

    // Rotations of the current link value force rotated picks
    for (int k = 0; k < 40; k++) begin
      int x = ref_link;
      step(1, (k % 2) ? rl(x) : rr(x));
    end

    // Random words with idle gaps (R6, R7)
    for (int k = 0; k < 400; k++) begin
      bit v = ($urandom % 4) != 0;
      step(v, int'($urandom % 256));
    end
    for (int k = 0; k < 3; k++) step(0, int'($urandom % 256));
    step(0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule